// File: doc/BRIEF.md
# Masked Cumulative Prefix Popcount Unit

The unit takes a vector of `VL` source bits and a predicate mask. For every element position it counts the source bits that are set, that have an active predicate, and that sit strictly below that position. The result is one `W`-bit count per element. A typical use is compacting or scattering active elements: each active lane learns its slot number among the selected elements that come before it.

Two flags change the inputs. The first makes the unit ignore the source vector and use all ones, so that with predication off the unit emits the index sequence 0, 1, 2, … VL-1. The second turns predication off, so every position counts as active. A lane whose predicate is inactive does not get a new count. It passes through the prior destination value for that lane, which the requester supplies along with the operation. Requests enter through a valid/ready handshake. The results come out registered one cycle after acceptance and are held while the consumer stalls.

Top module: `masked_prefix_count`

## Requirements
- R1: After reset, `outValid` is 0 and `reqReady` is 1.
- R2: For an active lane i, lane i of `outCounts` (bits `i*W +: W`) equals the number of positions j < i for which both the effective source bit and the effective mask bit are 1.
- R3: Lane 0 of an active request always reads 0.
- R4: When `noSrc` is 1, every source bit is taken as 1. With `noPred` also set, lane i reads i, so the lanes form 0..VL-1.
- R5: When `noPred` is 1, `maskBits` is ignored, every lane is active, and every bit counts as unmasked.
- R6: When `noPred` is 0 and `maskBits[i]` is 0, lane i of `outCounts` equals lane i of `oldDest` from the same request. Bit i then also adds nothing to the counts of higher lanes.
- R7: A request is accepted on a rising edge when `reqValid` and `reqReady` are both 1. `outValid` is 1 in the following cycle, and `outCounts` holds that request's result.
- R8: While `outValid` is 1 and `outReady` is 0, `reqReady` is 0, `outValid` stays 1 and `outCounts` does not change.
- R9: When a result is consumed (`outValid` and `outReady` are 1) and no request is accepted on the same edge, `outValid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit can accept a request |
| srcBits | input | VL | Source bit vector |
| maskBits | input | VL | Predicate mask, one bit per element |
| noSrc | input | 1 | Treat the source as all ones |
| noPred | input | 1 | Treat the mask as all ones |
| oldDest | input | VL*W | Prior destination lanes, lane i at bits i*W +: W |
| outValid | output | 1 | Result present |
| outReady | input | 1 | Consumer takes the result |
| outCounts | output | VL*W | Result lanes, lane i at bits i*W +: W |

## Verification
The bench builds the unit with VL = 8 and W = 4. At that size, all 256 source patterns are swept against eight mask patterns and all four flag combinations. This puts every lane's prefix count, each mix of active and inactive lanes, and the full-count lane 7 within reach of an arithmetic reference. Requests are issued back to back, so the accept-while-emitting path is exercised throughout. A separate stall sequence holds the consumer off to show that a new request is refused and the held result stays unchanged.

// File: rtl/prefix_count_pkg.sv
package prefix_count_pkg;

  // Strobes from the handshake control to the datapath
  typedef struct packed {
    logic load;   // capture a freshly computed result
  } ctrlStrobes_t;

  function automatic int countWidth(input int vl);
    return $clog2(vl) + 1;
  endfunction

endpackage

// File: rtl/prefix_count_ctrl.sv
module prefix_count_ctrl
  import prefix_count_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  input  logic         outReady,
  output logic         outValid,
  output ctrlStrobes_t strobes
);

  logic validQ;
  logic acceptReq;

  // A slot opens when the output is empty or is being drained this cycle
  assign reqReady  = !validQ || outReady;
  assign acceptReq = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
    end else if (acceptReq) begin
      validQ <= 1'b1;
    end else if (outReady) begin
      validQ <= 1'b0;
    end
  end

  always_comb begin
    strobes      = '0;
    strobes.load = acceptReq;
  end

  assign outValid = validQ;

endmodule

// File: rtl/prefix_count_datapath.sv
module prefix_count_datapath
  import prefix_count_pkg::*;
#(
  parameter int VL = 8,
  parameter int W  = countWidth(VL)
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobes_t    strobes,
  input  logic [VL-1:0]   srcBits,
  input  logic [VL-1:0]   maskBits,
  input  logic            noSrc,
  input  logic            noPred,
  input  logic [VL*W-1:0] oldDest,
  output logic [VL*W-1:0] outCounts
);

  logic [VL-1:0]   laneActive;
  logic [VL-1:0]   countBits;
  logic [VL*W-1:0] nextCounts;
  logic [VL*W-1:0] countsQ;

  // Per-lane qualification of the inputs
  for (genvar k = 0; k < VL; k++) begin : g_qualify
    assign laneActive[k] = noPred || maskBits[k];
    assign countBits[k]  = (noSrc || srcBits[k]) && laneActive[k];
  end

  // Each lane sums the qualified bits strictly below its own index
  for (genvar k = 0; k < VL; k++) begin : g_lane
    logic [W-1:0] belowSum;
    if (k == 0) begin : g_first
      assign belowSum = '0;
    end else begin : g_rest
      always_comb begin
        belowSum = '0;
        for (int j = 0; j < k; j++) begin
          belowSum = belowSum + W'(countBits[j]);
        end
      end
    end
    assign nextCounts[k*W +: W] = laneActive[k] ? belowSum : oldDest[k*W +: W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countsQ <= '0;
    end else if (strobes.load) begin
      countsQ <= nextCounts;
    end
  end

  assign outCounts = countsQ;

endmodule

// File: rtl/masked_prefix_count.sv
module masked_prefix_count
  import prefix_count_pkg::*;
#(
  parameter int VL = 8,
  localparam int W = countWidth(VL)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  output logic            reqReady,
  input  logic [VL-1:0]   srcBits,
  input  logic [VL-1:0]   maskBits,
  input  logic            noSrc,
  input  logic            noPred,
  input  logic [VL*W-1:0] oldDest,
  output logic            outValid,
  input  logic            outReady,
  output logic [VL*W-1:0] outCounts
);

  ctrlStrobes_t strobes;

  prefix_count_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .outReady (outReady),
    .outValid (outValid),
    .strobes  (strobes)
  );

  prefix_count_datapath #(.VL(VL), .W(W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .srcBits   (srcBits),
    .maskBits  (maskBits),
    .noSrc     (noSrc),
    .noPred    (noPred),
    .oldDest   (oldDest),
    .outCounts (outCounts)
  );

endmodule

// File: rtl/masked_prefix_count_chk.sv
module masked_prefix_count_chk
  import prefix_count_pkg::*;
#(
  parameter int VL = 8,
  localparam int W = countWidth(VL)
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic [VL-1:0]   srcBits,
  input logic [VL-1:0]   maskBits,
  input logic            noSrc,
  input logic            noPred,
  input logic [VL*W-1:0] oldDest,
  input logic            outValid,
  input logic            outReady,
  input logic [VL*W-1:0] outCounts
);

  logic accepted;
  assign accepted = reqValid && reqReady;

  // R7
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> outValid);

  // R8
  stall_blocks_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |-> !reqReady);

  // R8
  stall_holds_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outCounts)));

  // R9
  drain_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !accepted) |=> !outValid);

  // R3
  lane_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && (noPred || maskBits[0])) |=> (outCounts[W-1:0] == '0));

  // R6
  for (genvar k = 0; k < VL; k++) begin : g_keep
    keep_old_chk: assert property (@(posedge clk) disable iff (!rstN)
      (accepted && !noPred && !maskBits[k]) |=>
        (outCounts[k*W +: W] == $past(oldDest[k*W +: W])));
  end

endmodule

bind masked_prefix_count masked_prefix_count_chk #(.VL(VL)) u_chk (.*);

// File: tb/masked_prefix_count_tb.sv
module masked_prefix_count_tb;

  localparam int VL = 8;
  localparam int W  = 4;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            reqValid = 1'b0;
  logic            reqReady;
  logic [VL-1:0]   srcBits = '0;
  logic [VL-1:0]   maskBits = '0;
  logic            noSrc = 1'b0;
  logic            noPred = 1'b0;
  logic [VL*W-1:0] oldDest = '0;
  logic            outValid;
  logic            outReady = 1'b1;
  logic [VL*W-1:0] outCounts;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  masked_prefix_count #(.VL(VL)) u_dut (.*);

  function automatic logic [VL*W-1:0] refCounts(
      input logic [VL-1:0] s, input logic [VL-1:0] m,
      input logic ns, input logic np, input logic [VL*W-1:0] old);
    logic [VL*W-1:0] r;
    int run;
    r = '0;
    run = 0;
    for (int i = 0; i < VL; i++) begin
      bit act;
      act = np || m[i];
      r[i*W +: W] = act ? W'(run) : old[i*W +: W];
      if (act && (ns || s[i])) run++;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [VL*W-1:0] act,
                       input logic [VL*W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue one request, accepted on the next edge, then check its result
  task automatic runOne(input string req, input logic [VL-1:0] s,
                        input logic [VL-1:0] m, input logic ns,
                        input logic np, input logic [VL*W-1:0] old);
    srcBits  = s;
    maskBits = m;
    noSrc    = ns;
    noPred   = np;
    oldDest  = old;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check({req, " R7 valid"}, {{(VL*W-1){1'b0}}, outValid}, {{(VL*W-1){1'b0}}, 1'b1});
    check(req, outCounts, refCounts(s, m, ns, np, old));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [VL-1:0] masks [8];
    logic [VL*W-1:0] held;
    logic [VL*W-1:0] seqExp;
    masks = '{8'h00, 8'hFF, 8'hEB, 8'h55, 8'hAA, 8'h0F, 8'h81, 8'h7E};

    repeat (3) @(negedge clk);
    // R1
    check("R1 outValid", {{(VL*W-1){1'b0}}, outValid}, '0);
    check("R1 reqReady", {{(VL*W-1){1'b0}}, reqReady}, {{(VL*W-1){1'b0}}, 1'b1});
    rstN = 1'b1;
    @(negedge clk);

    // R2: source 10010001, no predication -> lanes 7..0 = 2,2,2,1,1,1,1,0
    runOne("R2 example", 8'b10010001, 8'h00, 1'b0, 1'b1, '0);
    check("R2 literal", outCounts, {4'd2,4'd2,4'd2,4'd1,4'd1,4'd1,4'd1,4'd0});

    // R6: masked example, old 2..9 on lanes 7..0 -> 1,1,1,5,1,7,1,0
    runOne("R6 example", 8'b10010001, 8'b11101011, 1'b0, 1'b0,
           {4'd2,4'd3,4'd4,4'd5,4'd6,4'd7,4'd8,4'd9});
    check("R6 literal", outCounts, {4'd1,4'd1,4'd1,4'd5,4'd1,4'd7,4'd1,4'd0});

    // R4: index sequence
    runOne("R4 sequence", 8'h00, 8'h00, 1'b1, 1'b1, {VL*W{1'b1}});
    seqExp = '0;
    for (int i = 0; i < VL; i++) seqExp[i*W +: W] = W'(i);
    check("R4 literal", outCounts, seqExp);

    // R9: result drained, no new request -> valid drops
    @(negedge clk);
    check("R9 drop", {{(VL*W-1){1'b0}}, outValid}, '0);

    // R2 R3 R5 R6: sweep sources x masks x flags, back to back
    for (int f = 0; f < 4; f++) begin
      for (int mi = 0; mi < 8; mi++) begin
        for (int s = 0; s < 256; s++) begin
          logic [VL*W-1:0] old;
          for (int i = 0; i < VL; i++) old[i*W +: W] = W'(s + 5*i + mi + f);
          runOne(f[1] ? "R5 sweep" : (f[0] ? "R4 sweep" : "R2 R3 R6 sweep"),
                 VL'(s), masks[mi], f[0], f[1], old);
        end
      end
    end

    // R8: stall, then a new request must be refused and data held
    outReady = 1'b0;
    runOne("R8 load", 8'hFF, 8'hFF, 1'b0, 1'b0, '0);
    held = outCounts;
    srcBits  = 8'h00;
    noSrc    = 1'b1;
    noPred   = 1'b1;
    reqValid = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R8 reqReady low", {{(VL*W-1){1'b0}}, reqReady}, '0);
      check("R8 held", outCounts, held);
      check("R8 valid held", {{(VL*W-1){1'b0}}, outValid}, {{(VL*W-1){1'b0}}, 1'b1});
    end
    // release: pending request accepted while draining
    outReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check("R7 after stall", outCounts, seqExp);
    @(negedge clk);
    check("R9 final drop", {{(VL*W-1){1'b0}}, outValid}, '0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule